// File: doc/BRIEF.md
# CAN FD Transmit Payload Padder

This block turns one transmit buffer element into the payload byte stream of a single frame. A 3-bit size setting states how many data bytes each buffer element holds. When a frame is launched, the frame's data length code sets how many bytes go out. Bytes that the element holds are fetched one at a time from buffer RAM through a synchronous read port. Any byte the code asks for beyond the element's capacity is sent as the fixed filler value 0xCC.

The size setting is protected. A write reaches it only while both the configuration-change-enable input and the init input are high, and it can be read back at any time. Sizes above 8 bytes are meant for flexible-data-rate frames only. The size is captured when a frame starts, so a later change does not disturb a frame that is already streaming. Bytes leave through a valid/ready stream, and a one-cycle done pulse marks the end of each frame.

Top module: `fd_pad_streamer`

## Requirements
- R1: The size code `cfg_rdata` resets to 0. Codes 0,1,2,3,4,5,6,7 give element capacities of 8,12,16,20,24,32,48,64 bytes.
- R2: A write (`cfg_wr_en`=1) loads `cfg_wdata` into the size code only when `cfg_cce`=1 and `cfg_init`=1 in the same cycle. Any other write leaves the code unchanged. `cfg_rdata` shows the code at all times.
- R3: A started frame emits exactly as many bytes as its code `dlc` asks for. Codes 0 to 8 ask for 0 to 8 bytes, and codes 9 to 15 ask for 12, 16, 20, 24, 32, 48 and 64 bytes.
- R4: Byte k of the frame, for k below min(requested count, element capacity), is the RAM word at address k. These reads are issued in increasing address order starting at 0, once each.
- R5: Byte k, for k at or above the element capacity, is 0xCC and causes no RAM read.
- R6: RAM read data is used in the cycle after `ram_rd_en`. The byte appears on `out_data` with `out_valid` one cycle after that.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` stays unchanged.
- R8: A frame with `dlc`=0 emits no byte and raises `done` in the cycle after `start`.
- R9: A `start` while `busy`=1 is ignored. The running frame keeps its length, and no second frame follows.
- R10: `done` is high for exactly one cycle, the cycle after the last byte handshake. It is never high while a byte is still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Size code write strobe |
| cfg_wdata | input | 3 | Size code write value |
| cfg_cce | input | 1 | Configuration change enable |
| cfg_init | input | 1 | Initialisation mode |
| cfg_rdata | output | 3 | Current size code |
| start | input | 1 | Launch one frame |
| dlc | input | 4 | Data length code of the launched frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| ram_rd_en | output | 1 | Buffer RAM read strobe |
| ram_addr | output | ADDR_W | Buffer RAM byte address |
| ram_rdata | input | 8 | Buffer RAM read data, one cycle after strobe |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | 8 | Output byte |

## Verification
The bound checker checks several rules on every cycle:
- the size code stays stable when no unlocked write occurs;
- the output is held under back-pressure;
- a read strobe is followed by an empty output cycle and then a loaded one;
- done lasts one cycle, only while idle;
- valid is never raised outside a frame.

Only the bench scenarios can show:
- the code-to-capacity and code-to-length tables;
- that the right RAM address feeds each byte;
- that filler bytes begin exactly at the element boundary;
- that a start during a frame really changes nothing.

They do this by comparing whole frames under several size codes, lengths and stall patterns.

// File: rtl/fdpad_pkg.sv
package fdpad_pkg;

  localparam int BYTE_W = 8;
  localparam int CODE_W = 3;
  localparam int DLC_W  = 4;
  localparam int CNT_W  = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SHOW  = 2'd3
  } fdpad_state_e;

  // element capacity in bytes for a size code
  function automatic logic [CNT_W-1:0] cap_bytes(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      3'd0:    r = 7'd8;
      3'd1:    r = 7'd12;
      3'd2:    r = 7'd16;
      3'd3:    r = 7'd20;
      3'd4:    r = 7'd24;
      3'd5:    r = 7'd32;
      3'd6:    r = 7'd48;
      default: r = 7'd64;
    endcase
    return r;
  endfunction

  // requested payload length for a length code
  function automatic logic [CNT_W-1:0] len_bytes(input logic [DLC_W-1:0] d);
    logic [CNT_W-1:0] r;
    case (d)
      4'd9:    r = 7'd12;
      4'd10:   r = 7'd16;
      4'd11:   r = 7'd20;
      4'd12:   r = 7'd24;
      4'd13:   r = 7'd32;
      4'd14:   r = 7'd48;
      4'd15:   r = 7'd64;
      default: r = {3'd0, d};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fdpad_size_reg.sv
module fdpad_size_reg #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wdata,
  input  logic              cce,
  input  logic              init,
  output logic [CODE_W-1:0] code
);

  logic              unlocked;
  logic              code_en;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    unlocked = cce & init;
    code_en  = wr_en & unlocked;
    code_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  assign code = code_q;

endmodule

// File: rtl/fdpad_frame_ctrl.sv
module fdpad_frame_ctrl
  import fdpad_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DLC_W-1:0]  dlc,
  input  logic [CODE_W-1:0] size_code,
  input  logic              hs,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              load_ram,
  output logic              load_pad,
  output logic              busy,
  output logic              done
);

  fdpad_state_e     state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] req_len;
  logic [CNT_W-1:0] cap_len;
  logic [CNT_W-1:0] idx_inc;

  always_comb begin
    req_len   = len_bytes(dlc);
    cap_len   = cap_bytes(size_code);
    idx_inc   = idx_q + 7'd1;
    state_d   = state_q;
    idx_d     = idx_q;
    total_d   = total_q;
    lim_d     = lim_q;
    done_d    = 1'b0;
    ram_rd_en = 1'b0;
    load_ram  = 1'b0;
    load_pad  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          idx_d   = '0;
          total_d = req_len;
          lim_d   = (req_len < cap_len) ? req_len : cap_len;
          if (req_len == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (idx_q < lim_q) begin
          ram_rd_en = 1'b1;
          state_d   = ST_WAIT;
        end else begin
          load_pad  = 1'b1;
          state_d   = ST_SHOW;
        end
      end
      ST_WAIT: begin
        load_ram = 1'b1;
        state_d  = ST_SHOW;
      end
      default: begin
        if (hs) begin
          idx_d = idx_inc;
          if (idx_inc == total_q) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_ISSUE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      total_q <= '0;
      lim_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      total_q <= total_d;
      lim_q   <= lim_d;
      done_q  <= done_d;
    end
  end

  assign ram_addr = idx_q[ADDR_W-1:0];
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;

endmodule

// File: rtl/fdpad_byte_stage.sv
module fdpad_byte_stage #(
  parameter int              W       = 8,
  parameter logic [W-1:0]    PAD_VAL = 8'hCC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_ram,
  input  logic         load_pad,
  input  logic [W-1:0] ram_rdata,
  input  logic         hs,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic         valid_q, valid_d;
  logic [W-1:0] data_q, data_d;
  logic         data_en;

  always_comb begin
    data_en = load_ram | load_pad;
    data_d  = load_ram ? ram_rdata : PAD_VAL;
    if (data_en) begin
      valid_d = 1'b1;
    end else if (hs) begin
      valid_d = 1'b0;
    end else begin
      valid_d = valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

endmodule

// File: rtl/fd_pad_streamer.sv
module fd_pad_streamer
  import fdpad_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter logic [7:0]  PAD_VAL = 8'hCC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [2:0]        cfg_wdata,
  input  logic              cfg_cce,
  input  logic              cfg_init,
  output logic [2:0]        cfg_rdata,
  input  logic              start,
  input  logic [3:0]        dlc,
  output logic              busy,
  output logic              done,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic [7:0]        ram_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data
);

  logic [CODE_W-1:0] size_code;
  logic              load_ram;
  logic              load_pad;
  logic              hs;

  assign hs        = out_valid & out_ready;
  assign cfg_rdata = size_code;

  fdpad_size_reg #(.CODE_W(CODE_W)) u_size (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr_en),
    .wdata (cfg_wdata),
    .cce   (cfg_cce),
    .init  (cfg_init),
    .code  (size_code)
  );

  fdpad_frame_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dlc       (dlc),
    .size_code (size_code),
    .hs        (hs),
    .ram_rd_en (ram_rd_en),
    .ram_addr  (ram_addr),
    .load_ram  (load_ram),
    .load_pad  (load_pad),
    .busy      (busy),
    .done      (done)
  );

  fdpad_byte_stage #(.W(BYTE_W), .PAD_VAL(PAD_VAL)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ram  (load_ram),
    .load_pad  (load_pad),
    .ram_rdata (ram_rdata),
    .hs        (hs),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/fdpad_checker.sv
module fdpad_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr_en,
  input logic       cfg_cce,
  input logic       cfg_init,
  input logic [2:0] cfg_rdata,
  input logic       busy,
  input logic       done,
  input logic       ram_rd_en,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data
);

  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_en && cfg_cce && cfg_init) |=> $stable(cfg_rdata));

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_read_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |=> (!out_valid && !ram_rd_en));

  assert_read_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |=> ##1 out_valid);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !out_valid));

  assert_valid_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

endmodule

bind fd_pad_streamer fdpad_checker u_fdpad_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr_en (cfg_wr_en),
  .cfg_cce   (cfg_cce),
  .cfg_init  (cfg_init),
  .cfg_rdata (cfg_rdata),
  .busy      (busy),
  .done      (done),
  .ram_rd_en (ram_rd_en),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/fd_pad_streamer_bench.sv
module fd_pad_streamer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic          clk;
  logic          rst_n;
  logic          cfg_wr_en;
  logic [2:0]    cfg_wdata;
  logic          cfg_cce;
  logic          cfg_init;
  logic [2:0]    cfg_rdata;
  logic          start;
  logic [3:0]    dlc;
  logic          busy;
  logic          done;
  logic          ram_rd_en;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_rdata;
  logic          out_valid;
  logic          out_ready;
  logic [7:0]    out_data;

  int checks = 0;
  int errors = 0;
  logic [2:0] code_model;

  fd_pad_streamer #(.ADDR_W(AW)) u_fd_pad_streamer (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_cce(cfg_cce),
    .cfg_init(cfg_init), .cfg_rdata(cfg_rdata),
    .start(start), .dlc(dlc), .busy(busy), .done(done),
    .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ram_word(input int a);
    return 8'(a * 3 + 1);
  endfunction

  always @(posedge clk) begin
    if (ram_rd_en) ram_rdata <= ram_word(int'(ram_addr));
  end

  function automatic int exp_cap(input logic [2:0] c);
    int t[8] = '{8, 12, 16, 20, 24, 32, 48, 64};
    return t[c];
  endfunction

  function automatic int exp_len(input logic [3:0] d);
    int t[7] = '{12, 16, 20, 24, 32, 48, 64};
    return (d <= 4'd8) ? int'(d) : t[int'(d) - 9];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] v, input logic cce, input logic ini);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wdata = v; cfg_cce = cce; cfg_init = ini;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_cce = 1'b0; cfg_init = 1'b0;
    if (cce && ini) code_model = v;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wdata = '0; cfg_cce = 1'b0; cfg_init = 1'b0;
    start = 1'b0; dlc = '0; out_ready = 1'b0; code_model = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rdata == 3'd0, "R1 reset code", int'(cfg_rdata), 0);
    check(!busy && !done && !out_valid && !ram_rd_en, "R10 idle after reset", int'(busy), 0);
  endtask

  task automatic t_cfg_lock();
    cfg_write(3'd5, 1'b1, 1'b0);
    check(cfg_rdata == code_model, "R2 write with init low", int'(cfg_rdata), int'(code_model));
    cfg_write(3'd6, 1'b0, 1'b1);
    check(cfg_rdata == code_model, "R2 write with cce low", int'(cfg_rdata), int'(code_model));
    cfg_write(3'd3, 1'b1, 1'b1);
    check(cfg_rdata == 3'd3, "R2 unlocked write", int'(cfg_rdata), 3);
    cfg_write(3'd0, 1'b1, 1'b1);
    check(cfg_rdata == 3'd0, "R2 unlocked write back", int'(cfg_rdata), 0);
  endtask

  task automatic run_frame(input logic [3:0] d, input int stall, input bit poke, input string tag);
    int n = exp_len(d);
    int cap = exp_cap(code_model);
    int lim = (n < cap) ? n : cap;
    int got = 0;
    int rdn = 0;
    int cyc = 0;
    bit holding = 0;
    logic [7:0] held = '0;
    @(negedge clk);
    start = 1'b1; dlc = d; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      check(done == 1'b1, {"R8 done after start ", tag}, int'(done), 1);
      check(!out_valid && !busy && !ram_rd_en, {"R8 no byte ", tag}, int'(out_valid), 0);
      @(negedge clk);
      check(done == 1'b0, {"R10 pulse width ", tag}, int'(done), 0);
      return;
    end
    while (got < n && cyc < 3000) begin
      cyc++;
      if (holding) begin
        check(out_valid && out_data == held, {"R7 hold ", tag}, int'(out_data), int'(held));
        holding = 0;
      end
      if (ram_rd_en) begin
        check(int'(ram_addr) == rdn && rdn < lim, {"R4 read address ", tag}, int'(ram_addr), rdn);
        rdn++;
      end
      if (done) check(1'b0, {"R10 early done ", tag}, 1, 0);
      start = (poke && got == 1) ? 1'b1 : 1'b0;
      dlc = poke ? 4'd15 : d;
      out_ready = (stall == 0) || (cyc % stall != 0);
      if (out_valid) begin
        if (out_ready) begin
          logic [7:0] e = (got < lim) ? ram_word(got) : 8'hCC;
          check(out_data == e, (got < lim) ? {"R4 R6 RAM byte ", tag} : {"R5 pad byte ", tag},
                int'(out_data), int'(e));
          got++;
        end else begin
          holding = 1; held = out_data;
        end
      end
      @(negedge clk);
    end
    start = 1'b0; out_ready = 1'b0;
    check(got == n, {"R3 byte count ", tag}, got, n);
    check(rdn == lim, {"R4 R5 read count ", tag}, rdn, lim);
    check(done == 1'b1, {"R10 done after last ", tag}, int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, {"R10 pulse width ", tag}, int'(done), 0);
    check(!busy && !out_valid, {"R9 no extra frame ", tag}, int'(busy), 0);
  endtask

  task automatic t_classic();
    run_frame(4'd5, 0, 1'b0, "dlc5");
    run_frame(4'd8, 0, 1'b0, "dlc8");
  endtask

  task automatic t_pad_small();
    run_frame(4'd12, 0, 1'b0, "code0 dlc12");
  endtask

  task automatic t_mid_sizes();
    cfg_write(3'd3, 1'b1, 1'b1);
    run_frame(4'd13, 0, 1'b0, "code3 dlc13");
    cfg_write(3'd1, 1'b1, 1'b1);
    run_frame(4'd9, 0, 1'b0, "code1 dlc9");
    cfg_write(3'd6, 1'b1, 1'b1);
    run_frame(4'd15, 0, 1'b0, "code6 dlc15");
  endtask

  task automatic t_full();
    cfg_write(3'd7, 1'b1, 1'b1);
    check(exp_cap(cfg_rdata) == 64, "R1 code7 capacity", int'(cfg_rdata), 7);
    run_frame(4'd15, 0, 1'b0, "code7 dlc15");
  endtask

  task automatic t_stall();
    cfg_write(3'd2, 1'b1, 1'b1);
    run_frame(4'd11, 3, 1'b0, "stall3");
    run_frame(4'd7, 2, 1'b0, "stall2");
  endtask

  task automatic t_zero();
    run_frame(4'd0, 0, 1'b0, "dlc0");
  endtask

  task automatic t_busy_start();
    cfg_write(3'd0, 1'b1, 1'b1);
    run_frame(4'd3, 0, 1'b1, "poke");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_cfg_lock();
    t_classic();
    t_pad_small();
    t_zero();
    t_mid_sizes();
    t_full();
    t_stall();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule